// File: doc/BRIEF.md
# Quasi-Bidirectional Port Pin Controller

This block is the digital side of an eight-pin quasi-bidirectional I/O port. Each pin has a resistive-style pull-up network and a pull-down transistor. The block holds the output latch and takes plain byte writes from the processor. It also runs two-phase read-modify-write operations: the latch value is presented in one cycle, and the modified byte is written back in the next cycle. A read returns either the latch or the synchronized pin level. For every pin, the block derives four drive enables: the pull-down, a strong pull-up pulse, a keeper pull-up fed by the pin, and a very weak pull-up.

A pin is used as an input by writing one to its latch. The pull-down then releases and the pull-ups hold the line high, so an external device can pull it low. When a peripheral function owns a pin, its alternate output decides the pull-down state while the latch is one. A latch of zero always drives the pin low. The pin level passes through a two-flop synchronizer before it reaches the read path or the keeper.

Top module: `qbport_ctrl`

## Requirements
- R1: After reset every latch bit is one. The latch read returns 0xFF, no pull-down or strong pull-up is enabled, and every very weak pull-up is enabled.
- R2: A plain write (`wr_en`) loads `wr_data` into the latch, and the value is visible in the cycle after the write.
- R3: With `rd_src` = 1, `rd_data` returns the latch value even when the pin is held low externally.
- R4: With `rd_src` = 0 and no read-modify-write active, `rd_data` returns the pin level after the two-flop synchronizer, two cycles after the pin changes.
- R5: During a cycle with `rmw_en` = 1, `rd_data` shows the latch value whatever `rd_src` is. The result is written back into the latch in the following cycle. The result is computed as follows, by `rmw_op` code: 00 gives latch AND `rmw_arg`, 01 gives OR, 10 gives XOR, and 11 gives latch plus one (modulo 256).
- R6: If a plain write falls in the write-back cycle of a read-modify-write, the plain write decides the latch.
- R7: Back-to-back read-modify-write operations chain. An operation issued in a write-back cycle sees, and modifies, the byte being written back.
- R8: Each latch bit that changes from zero to one enables its strong pull-up for exactly two cycles, starting in the cycle the latch shows one. The pulse is cut short if the bit returns to zero, and it restarts if the bit rises again.
- R9: The keeper pull-up enable of each pin equals the synchronized pin level.
- R10: The pull-down enable is the inverse of (latch AND effective alternate output). The effective alternate output of a pin is `alt_out` where `alt_sel` is one, and one where `alt_sel` is zero.
- R11: The very weak pull-up of a pin is enabled exactly when its pull-down is off.
- R12: Writing one to a latch bit that is already one does not start a strong pull-up pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Plain latch write strobe |
| wr_data | input | 8 | Byte for a plain write |
| rmw_en | input | 1 | Start a read-modify-write operation |
| rmw_op | input | 2 | Operation code: 00 AND, 01 OR, 10 XOR, 11 increment |
| rmw_arg | input | 8 | Operand for the read-modify-write |
| rd_src | input | 1 | Read source: 1 latch, 0 pin |
| rd_data | output | 8 | Read result |
| alt_sel | input | 8 | Per-pin alternate-function select |
| alt_out | input | 8 | Per-pin alternate-function output level |
| pin_in | input | 8 | Resolved pin levels |
| pd_en | output | 8 | Pull-down enable per pin |
| boost_en | output | 8 | Strong momentary pull-up enable per pin |
| keep_en | output | 8 | Keeper pull-up enable per pin |
| vweak_en | output | 8 | Very weak pull-up enable per pin |

## Verification
The read-modify-write write-back and a plain write can land in the same cycle, and so can a write-back and a new read-modify-write. The bench provokes the first by issuing an AND operation and then, in the next cycle, a plain write of a different byte. It passes only if the latch holds the plain byte afterwards. It provokes the second with a chain of OR, XOR and increment on consecutive cycles. The byte presented in each cycle, and the final latch value, must follow the chained results. The strong pull-up pulses during that chain must be cut short or restarted as bits fall and rise again.

// File: rtl/qbport_pkg.sv
// Shared types for the quasi-bidirectional port controller.
// Assumes: operation codes are fixed by the read-modify-write interface.
package qbport_pkg;
    typedef enum logic [1:0] {
        RMW_AND = 2'b00,
        RMW_OR  = 2'b01,
        RMW_XOR = 2'b10,
        RMW_INC = 2'b11
    } rmw_op_e;
endpackage

// File: rtl/qbport_sync.sv
// Multi-stage synchronizer for a bus of independent asynchronous bits.
// Assumes: each bit is sampled on its own; no bus coherence is required.
module qbport_sync #(
    parameter int W         = 8,
    parameter int STAGES    = 2,
    parameter logic [W-1:0] RESET_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // capture the raw input
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RESET_VAL;
                    else        stage_q[s] <= async_in;
                end
            end else begin : g_next
                // shift through the remaining stages
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= RESET_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/qbport_latch.sv
// Output latch with plain writes and two-phase read-modify-write.
// The view output forwards a pending write-back so chained operations
// see their predecessor's result. Plain writes win over a write-back.
// Assumes: one operation per cycle issued by the caller.
module qbport_latch
    import qbport_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rmw_en,
    input  rmw_op_e      rmw_op,
    input  logic [W-1:0] rmw_arg,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] latch_d,
    output logic [W-1:0] view,
    output logic         wb_busy
);
    logic [W-1:0] wb_data;
    logic [W-1:0] modified;

    // value the latch presents to readers, with write-back forwarded
    assign view    = wb_busy ? wb_data : latch_q;

    // compute the modified byte for a read-modify-write
    always_comb begin
        unique case (rmw_op)
            RMW_AND: modified = view & rmw_arg;
            RMW_OR:  modified = view | rmw_arg;
            RMW_XOR: modified = view ^ rmw_arg;
            default: modified = view + W'(1);
        endcase
    end

    // next latch value: plain write beats pending write-back
    always_comb begin
        if (wr_en)        latch_d = wr_data;
        else if (wb_busy) latch_d = wb_data;
        else              latch_d = latch_q;
    end

    // latch and write-back registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '1;
            wb_busy <= 1'b0;
            wb_data <= '0;
        end else begin
            latch_q <= latch_d;
            wb_busy <= rmw_en;
            if (rmw_en) wb_data <= modified;
        end
    end
endmodule

// File: rtl/qbport_boost.sv
// Per-pin timer for the strong pull-up pulse on a latch rising edge.
// Assumes: latch_d is the value the latch takes at the next clock edge.
module qbport_boost #(
    parameter int W      = 8,
    parameter int CYCLES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] latch_q,
    input  logic [W-1:0] latch_d,
    output logic [W-1:0] boost_en
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_pin
            logic [CNT_W-1:0] cnt;
            logic             rise;

            assign rise        = latch_d[i] & ~latch_q[i];
            assign boost_en[i] = (cnt != '0);

            // load on a rising edge, cancel on a drop, count down otherwise
            always_ff @(posedge clk) begin
                if (!rst_n)            cnt <= '0;
                else if (rise)         cnt <= CNT_W'(CYCLES);
                else if (!latch_d[i])  cnt <= '0;
                else if (cnt != '0)    cnt <= cnt - CNT_W'(1);
            end
        end
    endgenerate
endmodule

// File: rtl/qbport_ctrl.sv
// Quasi-bidirectional port controller top.
// Holds the output latch, serves latch and pin reads, and derives the
// pull-down, strong pull-up, keeper and very weak pull-up enables.
// Assumes: pin_in is the resolved pad level, asynchronous to clk.
module qbport_ctrl #(
    parameter int PORT_W       = 8,
    parameter int BOOST_CYCLES = 2,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_data,
    input  logic              rmw_en,
    input  logic [1:0]        rmw_op,
    input  logic [PORT_W-1:0] rmw_arg,
    input  logic              rd_src,
    output logic [PORT_W-1:0] rd_data,
    input  logic [PORT_W-1:0] alt_sel,
    input  logic [PORT_W-1:0] alt_out,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pd_en,
    output logic [PORT_W-1:0] boost_en,
    output logic [PORT_W-1:0] keep_en,
    output logic [PORT_W-1:0] vweak_en
);
    logic [PORT_W-1:0] latch_q;
    logic [PORT_W-1:0] latch_d;
    logic [PORT_W-1:0] latch_view;
    logic              wb_busy;
    logic [PORT_W-1:0] pin_sync;
    logic [PORT_W-1:0] alt_eff;

    qbport_sync #(.W(PORT_W), .STAGES(SYNC_STAGES), .RESET_VAL('1)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    qbport_latch #(.W(PORT_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rmw_en  (rmw_en),
        .rmw_op  (qbport_pkg::rmw_op_e'(rmw_op)),
        .rmw_arg (rmw_arg),
        .latch_q (latch_q),
        .latch_d (latch_d),
        .view    (latch_view),
        .wb_busy (wb_busy)
    );

    qbport_boost #(.W(PORT_W), .CYCLES(BOOST_CYCLES)) u_boost (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch_q  (latch_q),
        .latch_d  (latch_d),
        .boost_en (boost_en)
    );

    // read mux: a read-modify-write always reads the latch
    assign rd_data  = (rmw_en || rd_src) ? latch_view : pin_sync;

    // pins without an alternate function see a high alternate level
    assign alt_eff  = alt_out | ~alt_sel;

    // pad drive enables
    assign pd_en    = ~(latch_q & alt_eff);
    assign vweak_en = ~pd_en;
    assign keep_en  = pin_sync;
endmodule

// File: rtl/qbport_checker.sv
// Property checker for qbport_ctrl, attached by bind.
// Assumes: synchronous active-low reset held for at least one clock.
module qbport_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] latch_q,
    input logic [W-1:0] view,
    input logic         wb_busy,
    input logic         wr_en,
    input logic [W-1:0] wr_data,
    input logic         rmw_en,
    input logic [W-1:0] rd_data,
    input logic [W-1:0] boost_en,
    input logic [W-1:0] pd_en,
    input logic [W-1:0] vweak_en
);
    // R6: plain write in a write-back cycle decides the latch
    a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_busy && wr_en) |=> (latch_q == $past(wr_data)));

    // R5: a read-modify-write cycle presents the latch view
    a_r5_rmw_reads_latch: assert property (@(posedge clk) disable iff (!rst_n)
        rmw_en |-> (rd_data == view));

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            // R8: a rising latch bit has its strong pull-up on
            a_r8_boost_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
                (latch_q[i] && !$past(latch_q[i])) |-> boost_en[i]);

            // R8: the strong pull-up never runs against a zero latch
            a_r8_boost_needs_one: assert property (@(posedge clk) disable iff (!rst_n)
                boost_en[i] |-> latch_q[i]);

            // R10: a zero latch bit forces the pull-down
            a_r10_zero_pulls_down: assert property (@(posedge clk) disable iff (!rst_n)
                !latch_q[i] |-> pd_en[i]);

            // R11: very weak pull-up and pull-down never both on
            a_r11_vweak_excl: assert property (@(posedge clk) disable iff (!rst_n)
                pd_en[i] |-> !vweak_en[i]);
        end
    endgenerate
endmodule

bind qbport_ctrl qbport_checker #(.W(PORT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .latch_q  (latch_q),
    .view     (latch_view),
    .wb_busy  (wb_busy),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rmw_en   (rmw_en),
    .rd_data  (rd_data),
    .boost_en (boost_en),
    .pd_en    (pd_en),
    .vweak_en (vweak_en)
);

// File: tb/tb_qbport_ctrl.sv
// Scoreboard bench: drivers queue expected items per cycle, a monitor
// compares them at the falling edge.
module tb_qbport_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rmw_en = 1'b0;
    logic [1:0] rmw_op = '0;
    logic [7:0] rmw_arg = '0;
    logic       rd_src = 1'b1;
    logic [7:0] rd_data;
    logic [7:0] alt_sel = '0;
    logic [7:0] alt_out = '0;
    logic [7:0] pin_in = 8'hFF;
    logic [7:0] pd_en, boost_en, keep_en, vweak_en;

    qbport_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rmw_en(rmw_en), .rmw_op(rmw_op), .rmw_arg(rmw_arg), .rd_src(rd_src),
        .rd_data(rd_data), .alt_sel(alt_sel), .alt_out(alt_out), .pin_in(pin_in),
        .pd_en(pd_en), .boost_en(boost_en), .keep_en(keep_en), .vweak_en(vweak_en)
    );

    always #10 clk = ~clk;

    typedef struct {
        int         due;
        int         sig;
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] probe(int sig);
        case (sig)
            0: return rd_data;
            1: return pd_en;
            2: return boost_en;
            3: return keep_en;
            default: return vweak_en;
        endcase
    endfunction

    function automatic string sname(int sig);
        case (sig)
            0: return "rd_data";
            1: return "pd_en";
            2: return "boost_en";
            3: return "keep_en";
            default: return "vweak_en";
        endcase
    endfunction

    // driver side: queue an expectation in due order
    task automatic expect_at(int due, int sig, logic [7:0] v, string req);
        item_t it;
        int    pos;
        it.due = due; it.sig = sig; it.exp = v; it.req = req;
        pos = q.size();
        for (int k = 0; k < q.size(); k++) begin
            if (q[k].due > due) begin pos = k; break; end
        end
        q.insert(pos, it);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // monitor: compare everything due in this cycle
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            logic [7:0] act;
            it = q.pop_front();
            n_cmp++;
            act = probe(it.sig);
            if (it.due < cyc || act !== it.exp) begin
                n_bad++;
                $display("FAIL %s %s cycle %0d: actual %02h expected %02h",
                         it.req, sname(it.sig), it.due, act, it.exp);
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        int c;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        c = cyc;
        // R1 reset state
        expect_at(c, 0, 8'hFF, "R1");
        expect_at(c, 1, 8'h00, "R1");
        expect_at(c, 2, 8'h00, "R1");
        expect_at(c, 4, 8'hFF, "R1");
        step();

        // R2 plain write, R10/R11 drive from latch
        c = cyc;
        wr_en = 1'b1; wr_data = 8'h5A;
        expect_at(c + 1, 0, 8'h5A, "R2");
        expect_at(c + 1, 1, 8'hA5, "R10");
        expect_at(c + 1, 4, 8'h5A, "R11");
        expect_at(c + 1, 2, 8'h00, "R8");
        step();
        wr_en = 1'b0;
        step();
        // R8 strong pull-up on rising bits, exactly two cycles
        c = cyc;
        wr_en = 1'b1; wr_data = 8'hFF;
        expect_at(c + 1, 2, 8'hA5, "R8");
        expect_at(c + 2, 2, 8'hA5, "R8");
        expect_at(c + 3, 2, 8'h00, "R8");
        step();
        wr_en = 1'b0;
        repeat (3) step();

        // R3 latch read with pin low, R4 pin read, R9 keeper
        c = cyc;
        pin_in = 8'h0F; rd_src = 1'b1;
        expect_at(c, 0, 8'hFF, "R3");
        expect_at(c + 2, 3, 8'h0F, "R9");
        step();
        rd_src = 1'b0;
        expect_at(c + 1, 0, 8'hFF, "R4");
        expect_at(c + 2, 0, 8'h0F, "R4");
        step();
        step();
        pin_in = 8'hFF; rd_src = 1'b1;
        repeat (3) step();

        // R5 AND operation: presents latch, writes back next cycle
        c = cyc;
        rd_src = 1'b0;
        rmw_en = 1'b1; rmw_op = 2'b00; rmw_arg = 8'h3C;
        expect_at(c, 0, 8'hFF, "R5");
        expect_at(c + 2, 0, 8'h3C, "R5");
        step();
        rmw_en = 1'b0; rd_src = 1'b1;
        step();
        step();

        // R7 chained OR, XOR, increment with R8 cancel/restart
        c = cyc;
        rmw_en = 1'b1; rmw_op = 2'b01; rmw_arg = 8'h41;
        expect_at(c, 0, 8'h3C, "R7");
        expect_at(c + 1, 0, 8'h7D, "R7");
        expect_at(c + 2, 0, 8'h82, "R7");
        expect_at(c + 4, 0, 8'h83, "R5");
        expect_at(c + 2, 2, 8'h41, "R8");
        expect_at(c + 3, 2, 8'h82, "R8");
        expect_at(c + 4, 2, 8'h83, "R8");
        expect_at(c + 5, 2, 8'h01, "R8");
        expect_at(c + 6, 2, 8'h00, "R8");
        step();
        rmw_op = 2'b10; rmw_arg = 8'hFF;
        step();
        rmw_op = 2'b11; rmw_arg = 8'h00;
        step();
        rmw_en = 1'b0;
        repeat (4) step();

        // R6 plain write in write-back cycle wins
        c = cyc;
        rmw_en = 1'b1; rmw_op = 2'b00; rmw_arg = 8'h0F;
        step();
        rmw_en = 1'b0;
        wr_en = 1'b1; wr_data = 8'hF0;
        expect_at(c + 2, 0, 8'hF0, "R6");
        expect_at(c + 3, 0, 8'hF0, "R6");
        step();
        wr_en = 1'b0;
        repeat (2) step();

        // R10 alternate output decides pull-down where latch is one
        c = cyc;
        alt_sel = 8'h30; alt_out = 8'h10;
        expect_at(c, 1, 8'h2F, "R10");
        expect_at(c, 4, 8'hD0, "R11");
        step();
        alt_sel = 8'h00; alt_out = 8'h00;
        step();

        // R12 writing one over one starts no pulse
        c = cyc;
        wr_en = 1'b1; wr_data = 8'hFF;
        expect_at(c + 1, 2, 8'h0F, "R8");
        step();
        wr_en = 1'b0;
        repeat (2) step();
        c = cyc;
        wr_en = 1'b1; wr_data = 8'hFF;
        expect_at(c + 1, 2, 8'h00, "R12");
        expect_at(c + 1, 0, 8'hFF, "R12");
        step();
        wr_en = 1'b0;
        repeat (3) step();

        if (q.size() != 0) begin
            n_bad += q.size();
            $display("FAIL scoreboard: actual %0d left expected 0", q.size());
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule